// File: doc/BRIEF.md
# Byte-Lane Load/Store Port with Selectable Endianness

This block sits between a processor's load/store path and a memory that is 32 bits wide and addressed by byte. Each request carries a byte address, an access size, a read/write flag, store data, a sign-extension flag and an endianness select. The port turns the request into a word-aligned memory address, a per-lane byte-enable mask and store data placed in the right lanes. For loads it collects the addressed bytes from the returned word and orders them into a right-justified result.

Byte order inside a word is chosen per request. In little-endian order the least significant byte of the value lives at the lowest byte address. In big-endian order the most significant byte lives there. A request whose address is not a multiple of its size is not split. It is flagged as an error and never reaches memory. Requests of 64 bits are always refused.

The port takes one access per cycle with a valid/ready handshake on the request side. Memory strobes are driven in the same cycle as the accepted request. The memory returns read data one cycle later, and the response appears in that cycle.

Top module: `lane_port`

## Requirements
- R1: Little-endian store: value byte i (byte 0 is bits 7:0) is driven on memory lane (addr[1:0] + i), where lane k is mem_wdata bits 8k+7:8k, and mem_be has exactly those lanes set.
- R2: Big-endian store: value byte i of an n-byte access is driven on memory lane (addr[1:0] + n - 1 - i), and mem_be has exactly the lanes of the access set.
- R3: Little-endian load: result byte i is taken from the byte at address addr + i, right-justified in rsp_rdata.
- R4: Big-endian load: result byte i of an n-byte access is taken from the byte at address addr + n - 1 - i, right-justified in rsp_rdata.
- R5: Size codes are 0 = byte, 1 = halfword, 2 = word. A halfword is misaligned when addr[0] is 1. A word is misaligned when addr[1:0] is not 0. A byte access is never misaligned.
- R6: Size code 3 (64-bit) is refused with an error whatever the address.
- R7: A misaligned or refused request holds mem_en low with mem_be at zero, changes no memory byte, and answers with rsp_err = 1 and rsp_rdata = 0.
- R8: Byte and halfword loads are zero-extended when req_signed is 0 and sign-extended from the top loaded bit when req_signed is 1. Word loads are unaffected by req_signed.
- R9: A request is taken in a cycle where req_valid and req_ready are both 1. rsp_valid is 1 exactly in the following cycle. req_ready and rsp_valid are 0 while rst is 1, and req_ready is 1 from the first clock edge after rst falls.
- R10: mem_addr is req_addr with its two low bits cleared, and a store answers with rsp_rdata = 0 and rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can take a request |
| req_addr | input | ADDR_W | Byte address (unsigned) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store value, right-justified |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_big | input | 1 | 1 big-endian, 0 little-endian |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Memory read word, valid one cycle after mem_en |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was misaligned or refused |
| rsp_rdata | output | 32 | Right-justified load result |

## Verification
The memory address, enables and lane-placed store data follow the request combinationally, so the bench samples them in the same cycle it drives the request, a short delay after it drives it. The response flag, error bit and load result become due one clock edge later, together with the memory's registered read word. The bench reads them at the falling edge that follows that edge. A reference model of the handshake, advanced on every rising edge, predicts req_ready and rsp_valid for each cycle and is compared at every falling edge. A separate byte-array reference memory predicts every load value and every lane pattern.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Captured control of an accepted access, carried to the response cycle.
    typedef struct packed {
        logic [OFF_W-1:0] off;
        acc_size_e        size;
        logic             big;
        logic             sext;
        logic             write;
        logic             err;
    } lane_ctl_t;

    function automatic int unsigned size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 8;
        endcase
    endfunction

    // Memory lane that holds byte idx (0 = least significant) of the value.
    function automatic logic [OFF_W-1:0] lane_of(logic [OFF_W-1:0] off, acc_size_e s,
                                                 logic big, int unsigned idx);
        int unsigned n;
        int unsigned p;
        n = size_bytes(s);
        p = big ? (int'(off) + n - 1 - idx) : (int'(off) + idx);
        return OFF_W'(p);
    endfunction

endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
    import lane_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output logic             err
);
    logic [OFF_W:0] mask;
    logic           too_wide;

    always_comb begin
        too_wide = size_bytes(size) > LANES;
        mask     = (OFF_W+1)'(size_bytes(size) - 1);
        err      = too_wide || ((off & mask[OFF_W-1:0]) != '0);
    end
endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer
    import lane_pkg::*;
(
    input  logic              en,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              big,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    always_comb begin
        be        = '0;
        lane_data = '0;
        for (int i = 0; i < LANES; i++) begin
            if (en && (i < int'(size_bytes(size)))) begin
                be[lane_of(off, size, big, i)] = 1'b1;
                lane_data[BYTE_W*int'(lane_of(off, size, big, i)) +: BYTE_W] =
                    wdata[BYTE_W*i +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/lane_rd_gather.sv
module lane_rd_gather
    import lane_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              big,
    input  logic              sext,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] raw;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_byte
        logic [BYTE_W-1:0] pick;
        assign pick = rdata[BYTE_W*int'(lane_of(off, size, big, gi)) +: BYTE_W];
        assign raw[BYTE_W*gi +: BYTE_W] = (gi < int'(size_bytes(size))) ? pick : '0;
    end

    always_comb begin
        logic sign;
        int   n;
        n      = int'(size_bytes(size));
        sign   = 1'b0;
        result = raw;
        if (sext && (n < LANES)) begin
            sign = raw[BYTE_W*n - 1];
            for (int i = 1; i < LANES; i++)
                if (i >= n) result[BYTE_W*i +: BYTE_W] = {BYTE_W{sign}};
        end
    end
endmodule

// File: rtl/lane_port.sv
module lane_port
    import lane_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_signed,
    input  logic              req_big,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              ready_q;
    logic              fire;
    logic              bad;
    acc_size_e         size_e;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] steer_data;
    logic [DATA_W-1:0] load_val;
    logic              rsp_q;
    lane_ctl_t         ctl_q;

    assign size_e    = acc_size_e'(req_size);
    assign off       = req_addr[OFF_W-1:0];
    assign req_ready = ready_q;
    assign fire      = req_valid && ready_q;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    lane_align_chk u_align (
        .off  (off),
        .size (size_e),
        .err  (bad)
    );

    assign mem_en   = fire && !bad;
    assign mem_we   = mem_en && req_write;
    assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    lane_wr_steer u_steer (
        .en        (mem_en),
        .off       (off),
        .size      (size_e),
        .big       (req_big),
        .wdata     (req_wdata),
        .be        (mem_be),
        .lane_data (steer_data)
    );

    assign mem_wdata = mem_we ? steer_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= 1'b0;
            ctl_q <= '0;
        end else begin
            rsp_q <= fire;
            if (fire) begin
                ctl_q.off   <= off;
                ctl_q.size  <= size_e;
                ctl_q.big   <= req_big;
                ctl_q.sext  <= req_signed;
                ctl_q.write <= req_write;
                ctl_q.err   <= bad;
            end
        end
    end

    lane_rd_gather u_gather (
        .rdata  (mem_rdata),
        .off    (ctl_q.off),
        .size   (ctl_q.size),
        .big    (ctl_q.big),
        .sext   (ctl_q.sext),
        .result (load_val)
    );

    assign rsp_valid = rsp_q;
    assign rsp_err   = rsp_q && ctl_q.err;
    assign rsp_rdata = (rsp_q && !ctl_q.write && !ctl_q.err) ? load_val : '0;

    // Lane count of a memory access matches its size code.
    assert_be_count_R1: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ($countones(mem_be) == int'(size_bytes(size_e))));

    // Halfword strobes only for even addresses.
    assert_half_align_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_en && req_size == 2'd1) |-> !req_addr[0]);

    // Doubleword requests never reach memory.
    assert_dword_block_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && req_size == 2'd3) |-> (!mem_en && mem_be == '0));

    // Error responses carry no data.
    assert_err_nodata_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    // Response exactly one cycle after acceptance.
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_rsp_only_after_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    // Stores acknowledge with zero data.
    assert_store_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && req_write && req_size != 2'd3) |=> (rsp_rdata == '0));

endmodule

// File: tb/sim_lane_port.sv
`timescale 1ns/1ps
module sim_lane_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_signed = 1'b0;
    logic        req_big = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    bit  exp_rdy  = 0;
    bit  exp_vld  = 0;
    bit  started  = 0;

    logic [7:0] bmem  [1024];
    logic [7:0] ref_m [1024];

    always #2.5 clk = ~clk;

    lane_port u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_signed(req_signed), .req_big(req_big),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // Behavioural memory: registered read, per-lane write.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) bmem[{mem_addr[9:2], 2'(k)}] = mem_wdata[8*k +: 8];
            end else begin
                for (int k = 0; k < 4; k++)
                    mem_rdata[8*k +: 8] <= bmem[{mem_addr[9:2], 2'(k)}];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Handshake model, advanced every rising edge, compared every falling edge.
    always @(posedge clk) begin
        exp_vld <= !rst && req_valid && exp_rdy;
        exp_rdy <= !rst;
        started <= 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(req_ready == exp_rdy, "R9 ready", 32'(req_ready), 32'(exp_rdy));
            chk(rsp_valid == exp_vld, "R9 rsp_valid", 32'(rsp_valid), 32'(exp_vld));
        end
    end

    task automatic access(input int addr, input int sz, input bit wr,
                          input logic [31:0] wd, input bit sg, input bit bg,
                          input string tag);
        int          n;
        bit          bad;
        int          off;
        logic [3:0]  ebe;
        logic [31:0] ewd, mask, ev;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
        bad = (sz == 3) || ((addr % n) != 0);
        off = addr % 4;
        ebe = '0; ewd = '0; mask = '0; ev = '0;
        if (!bad) begin
            for (int i = 0; i < n; i++) begin
                int ln;
                ln = bg ? (off + n - 1 - i) : (off + i);
                ebe[ln] = 1'b1;
                ewd[8*ln +: 8] = wd[8*i +: 8];
                mask[8*ln +: 8] = 8'hFF;
            end
            if (!wr) begin
                for (int i = 0; i < n; i++)
                    ev[8*i +: 8] = ref_m[bg ? (addr + n - 1 - i) : (addr + i)];
                if (sg && n < 4 && ev[8*n-1])
                    for (int i = n; i < 4; i++) ev[8*i +: 8] = 8'hFF;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr[15:0]; req_size = sz[1:0];
        req_write = wr; req_wdata = wd; req_signed = sg; req_big = bg;
        #0.5;
        chk(mem_en == !bad, {tag, " mem_en"}, 32'(mem_en), 32'(!bad));
        chk(mem_be == ebe, {tag, " mem_be"}, 32'(mem_be), 32'(ebe));
        if (!bad) begin
            chk(mem_addr == 16'(addr & ~3), {tag, " R10 mem_addr"}, 32'(mem_addr),
                32'(addr & ~3));
            chk(mem_we == wr, {tag, " mem_we"}, 32'(mem_we), 32'(wr));
            if (wr) begin
                chk((mem_wdata & mask) == ewd, {tag, " mem_wdata"}, mem_wdata & mask, ewd);
                for (int i = 0; i < n; i++)
                    ref_m[bg ? (addr + n - 1 - i) : (addr + i)] = wd[8*i +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " R9 rsp"}, 32'(rsp_valid), 32'd1);
        chk(rsp_err == bad, {tag, " err"}, 32'(rsp_err), 32'(bad));
        chk(rsp_rdata == ev, {tag, " rdata"}, rsp_rdata, ev);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i]  = 8'(i * 7 + 3);
            ref_m[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b0, "R9 reset ready", 32'(req_ready), 32'd0);
        chk(rsp_valid == 1'b0, "R9 reset rsp", 32'(rsp_valid), 32'd0);
        chk(mem_en == 1'b0, "R9 reset mem_en", 32'(mem_en), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);

        // R1 / R3: little-endian word round trip
        access('h10, 2, 1, 32'h11223344, 0, 0, "R1 LE word store");
        access('h10, 2, 0, 0, 0, 0, "R3 LE word load");
        // R4: big-endian view of the same bytes
        access('h10, 2, 0, 0, 0, 1, "R4 BE word load");
        access('h10, 0, 0, 0, 0, 1, "R4 BE byte load");
        // R2: big-endian stores
        access('h20, 2, 1, 32'hA1B2C3D4, 0, 1, "R2 BE word store");
        access('h20, 1, 0, 0, 0, 0, "R3 LE half load");
        access('h22, 1, 0, 0, 0, 1, "R4 BE half load hi");
        access('h41, 0, 1, 32'h0000005A, 0, 1, "R2 BE byte store lane1");
        access('h46, 1, 1, 32'h00001357, 0, 1, "R2 BE half store upper");
        access('h44, 2, 0, 0, 0, 0, "R3 LE word after BE half");
        // R1: little-endian half store
        access('h32, 1, 1, 32'h0000BEEF, 0, 0, "R1 LE half store");
        access('h33, 0, 0, 0, 0, 0, "R5 odd byte load");
        // R8: extension
        access('h33, 0, 0, 0, 1, 0, "R8 signed byte");
        access('h32, 1, 0, 0, 1, 0, "R8 signed half");
        access('h32, 1, 0, 0, 0, 0, "R8 unsigned half");
        access('h10, 2, 0, 0, 1, 1, "R8 signed word");
        access('h41, 0, 0, 0, 1, 0, "R8 positive signed byte");
        // R5 / R6 / R7: misaligned and refused
        access('h21, 1, 1, 32'hFFFF, 0, 0, "R5 R7 odd half store");
        access('h22, 2, 1, 32'hFFFFFFFF, 0, 1, "R5 R7 half-offset word store");
        access('h23, 2, 0, 0, 0, 0, "R5 R7 offset-3 word load");
        access('h00, 3, 1, 32'hDEADBEEF, 0, 0, "R6 R7 dword store");
        access('h08, 3, 0, 0, 0, 1, "R6 dword load");
        access('h20, 2, 0, 0, 0, 1, "R7 memory unchanged");
        // R10: high address, word address clearing
        access('h3FE, 1, 1, 32'h00002468, 0, 0, "R10 high half store");
        access('h3FC, 2, 0, 0, 0, 0, "R10 high word load");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule